// File: doc/BRIEF.md
# SAR ADC serial device emulator

This block plays the device side of a 12-bit successive-approximation converter that has a chip-select/serial-clock read port. It can stand in for the real converter inside an FPGA or a simulation. A fast system clock oversamples three inputs, all active-low or idle-low: conversion start, chip select and serial clock. Each input passes through a two-flop synchronizer before edge detection. The block returns serial data as a value with a separate output-enable, and a pad outside the block builds the tri-state driver from the two. It takes the next conversion result from a parallel sample port. Every time window is counted in system-clock cycles and derived from a clock-frequency parameter.

The block starts uninitialised. A soft reset happens when a read is aborted partway through. One further conversion then has to run to completion, and only after that does the ready output rise. The block has two read modes, and the master switches between them with chip-select timing alone. In normal mode, the master reads 12 bits once the conversion window has ended. In busy-indicator mode, chip select is already low during the conversion. The data line then signals completion by going low, and the read takes 13 serial clocks. A read of the wrong length and a conversion start that comes too soon after a read both count as timing errors. Each one sets a sticky flag and increments a saturating counter.

Top module: `sar_adc_emu`

## Requirements
- R1: Reset drives all outputs to their idle values: output enable 0, ready 0, busy mode 0, error flag 0, error count 0.
- R2: In normal mode, a chip-select fall after the conversion window presents result bit 11. Each serial-clock fall then presents the next lower bit, so bits 11 down to 0 leave MSB first. The result is the value on the sample port when the conversion completed (650 ns after the conversion-start fall), and later changes on that port do not affect it.
- R3: The output enable is 0 whenever chip select is high. It also drops on the 12th serial-clock fall of a normal read and on the 13th fall of a busy-indicator read.
- R4: A read that ends after 2 to 8 serial-clock falls is a soft reset, unless 2 to 8 is exactly the expected length. A soft reset drops ready, clears busy-indicator mode at once and counts no error.
- R5: After a soft reset, ready rises when the next conversion completes.
- R6: In normal mode, chip select may fall and rise again inside the conversion window with no serial-clock fall in between. That pulse arms busy-indicator mode, and busy_mode_o rises at the next conversion-start fall.
- R7: In busy-indicator mode, chip select is low during the conversion. The data line is then driven 1 until the conversion completes and 0 afterwards as the done flag. Serial-clock falls 1 to 12 present result bits 11 down to 0.
- R8: Suppose the block is in busy-indicator mode and chip select first falls after the conversion window. That read is a normal 12-bit read, and busy_mode_o falls at the next conversion-start fall.
- R9: A conversion-start fall less than 50 ns after the chip-select rise that ends a read is a timing error. The conversion still runs.
- R10: A read that ends with a count other than the expected length (12 in normal mode, 13 in busy mode) and outside 2 to 8 is a timing error. So is a serial-clock fall while chip select is low during the conversion window. Each timing error sets the sticky flag and adds 1 to the 16-bit counter, which saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n_i | input | 1 | Conversion start, active on its falling edge |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock; data changes on its falling edge |
| sample_i | input | DATA_W | Value taken as the result when a conversion completes |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data output enable; 0 means high impedance |
| ready_o | output | 1 | Soft-reset sequence complete |
| busy_mode_o | output | 1 | Busy-indicator mode active for the running conversion |
| err_o | output | 1 | Sticky timing-error flag |
| err_cnt_o | output | ERR_W | Saturating timing-error count |

## Verification
Normal reads sweep walking ones, all zeros, all ones and two alternating patterns. This separates bit order, off-by-one shifts and stuck bits. The sample port is changed after every conversion completes, which shows that the result is latched at completion. Abort lengths are swept across the whole soft-reset band and several lengths outside it, so the read-length decision is pinned down on both sides of each boundary. Busy-mode reads of eight distinct values check the drive-high phase, the done flag and the extra clock. The mode is entered through the arming pulse and left through a late chip select, and one sequence aborts a busy-mode read to show that a soft reset clears the mode.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;
  // Read-side phases of the emulated converter
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // no conversion running
    ST_CONV  = 3'd1,  // converting, chip select high
    ST_ARM   = 3'd2,  // converting, chip select low in normal mode
    ST_BWAIT = 3'd3,  // converting, chip select low in busy mode
    ST_READ  = 3'd4   // shifting result out
  } emu_state_e;
endpackage

// File: rtl/sar_emu_sync.sv
module sar_emu_sync #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
        s3_q <= RST_VAL[g];
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign fall_o[g] = s3_q & ~s2_q;
    assign rise_o[g] = ~s3_q & s2_q;
  end
endmodule

// File: rtl/sar_emu_timer.sv
module sar_emu_timer #(
  parameter int unsigned LIMIT = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic run_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)          cnt_d = CW'(LIMIT);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign run_o  = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !start_i;
endmodule

// File: rtl/sar_emu_shift.sv
module sar_emu_shift #(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = $clog2(W + 2) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [W:0]    val_i,
  input  logic [CW-1:0] len_i,
  input  logic          shift_i,
  output logic          bit_o,
  output logic          oe_o,
  output logic [CW-1:0] cnt_o
);
  logic [W:0]    sh_q, sh_d;
  logic          oe_q, oe_d;
  logic [CW-1:0] cnt_q, cnt_d, len_q, len_d;

  always_comb begin
    sh_d  = sh_q;
    oe_d  = oe_q;
    cnt_d = cnt_q;
    len_d = len_q;
    if (clr_i) begin
      oe_d = 1'b0;
    end
    if (load_i) begin
      sh_d  = val_i;
      oe_d  = 1'b1;
      cnt_d = '0;
      len_d = len_i;
    end else if (shift_i) begin
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
      if (oe_q) begin
        sh_d = {sh_q[W-1:0], 1'b0};
        if ((cnt_q + 1'b1) >= len_q) oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      oe_q  <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      sh_q  <= sh_d;
      oe_q  <= oe_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign bit_o = sh_q[W];
  assign oe_o  = oe_q;
  assign cnt_o = cnt_q;

  // R3: the driver is never left on past the programmed read length
  p_oe_in_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (cnt_q < len_q));
endmodule

// File: rtl/sar_emu_err.sv
module sar_emu_err #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    flag_d = flag_q | hit_i;
    cnt_d  = cnt_q;
    if (hit_i && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign err_o = flag_q;
  assign cnt_o = cnt_q;

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
  p_count_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/sar_adc_emu.sv
module sar_adc_emu
  import sar_emu_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned CONV_NS   = 650,
  parameter int unsigned QUIET_NS  = 50,
  parameter int unsigned ABORT_MIN = 2,
  parameter int unsigned ABORT_MAX = 8,
  parameter int unsigned ERR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_n_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              ready_o,
  output logic              busy_mode_o,
  output logic              err_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam int unsigned CONV_CYC  = (CONV_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned QUIET_CYC = (QUIET_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned CW        = $clog2(DATA_W + 2) + 1;
  localparam int unsigned RD_NORM   = DATA_W;
  localparam int unsigned RD_BUSY   = DATA_W + 1;

  // ---------------- input conditioning: {sclk, cs, conv}
  logic [2:0] in_lvl, in_fall, in_rise;
  sar_emu_sync #(.N(3), .RST_VAL(3'b011)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({sclk_i, cs_n_i, conv_n_i}),
    .lvl_o  (in_lvl),
    .fall_o (in_fall),
    .rise_o (in_rise)
  );
  logic conv_fall, cs_fall, cs_rise, cs_lvl, sclk_fall;
  assign conv_fall = in_fall[0];
  assign cs_fall   = in_fall[1];
  assign cs_rise   = in_rise[1];
  assign cs_lvl    = in_lvl[1];
  assign sclk_fall = in_fall[2];
  logic unused_sync;
  assign unused_sync = ^{in_lvl[0], in_lvl[2], in_rise[0], in_rise[2]};

  // ---------------- timers
  logic conv_start, conv_run, conv_done;
  logic quiet_start, quiet_run, quiet_done;
  sar_emu_timer #(.LIMIT(CONV_CYC)) u_conv_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start), .run_o(conv_run), .done_o(conv_done)
  );
  sar_emu_timer #(.LIMIT(QUIET_CYC)) u_quiet_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(quiet_start), .run_o(quiet_run), .done_o(quiet_done)
  );
  logic unused_tmr;
  assign unused_tmr = conv_run ^ quiet_done;

  // ---------------- output shifter
  logic              sh_clr, sh_load, sh_bit, sh_oe;
  logic [DATA_W:0]   sh_val;
  logic [CW-1:0]     sh_len, sh_cnt;
  sar_emu_shift #(.W(DATA_W), .CW(CW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (sh_clr),
    .load_i (sh_load),
    .val_i  (sh_val),
    .len_i  (sh_len),
    .shift_i(sclk_fall),
    .bit_o  (sh_bit),
    .oe_o   (sh_oe),
    .cnt_o  (sh_cnt)
  );

  // ---------------- error accumulator
  logic err_hit;
  sar_emu_err #(.CNT_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .hit_i(err_hit), .err_o(err_o), .cnt_o(err_cnt_o)
  );

  // ---------------- control state
  emu_state_e        st_q, st_d;
  logic              busy_mode_q, busy_mode_d;
  logic              busy_next_q, busy_next_d;
  logic              init_q, init_d;
  logic              rst_pend_q, rst_pend_d;
  logic              early_q, early_d;
  logic              rd_busy_q, rd_busy_d;
  logic [DATA_W-1:0] result_q, result_d;
  logic [CW-1:0]     rd_exp;

  assign rd_exp = rd_busy_q ? CW'(RD_BUSY) : CW'(RD_NORM);

  always_comb begin
    st_d        = st_q;
    busy_mode_d = busy_mode_q;
    busy_next_d = busy_next_q;
    init_d      = init_q;
    rst_pend_d  = rst_pend_q;
    early_d     = early_q;
    rd_busy_d   = rd_busy_q;
    result_d    = result_q;
    conv_start  = 1'b0;
    quiet_start = 1'b0;
    sh_clr      = 1'b0;
    sh_load     = 1'b0;
    sh_val      = {result_q, 1'b0};
    sh_len      = CW'(RD_NORM);
    err_hit     = 1'b0;

    // Completion: capture sample, finish a pending soft reset
    if (conv_done) begin
      result_d = sample_i;
      if (rst_pend_q) begin
        init_d     = 1'b1;
        rst_pend_d = 1'b0;
      end
    end

    unique case (st_q)
      ST_IDLE: begin
        if (conv_fall) begin
          conv_start  = 1'b1;
          busy_mode_d = busy_next_q;
          err_hit     = quiet_run;
          st_d        = ST_CONV;
        end else if (cs_fall) begin
          sh_load   = 1'b1;
          rd_busy_d = 1'b0;
          if (busy_mode_q) busy_next_d = 1'b0;
          st_d = ST_READ;
        end
      end
      ST_CONV: begin
        if (conv_done) begin
          st_d = ST_IDLE;
        end else if (cs_fall) begin
          early_d = 1'b0;
          st_d    = busy_mode_q ? ST_BWAIT : ST_ARM;
        end
      end
      ST_ARM: begin
        if (sclk_fall && !early_q) begin
          early_d = 1'b1;
          err_hit = 1'b1;
        end
        if (conv_done) begin
          if (cs_rise) begin
            st_d = ST_IDLE;
          end else begin
            sh_load   = 1'b1;
            sh_val    = {sample_i, 1'b0};
            rd_busy_d = 1'b0;
            st_d      = ST_READ;
          end
        end else if (cs_rise) begin
          if (!early_q && !sclk_fall) busy_next_d = 1'b1;
          st_d = ST_CONV;
        end
      end
      ST_BWAIT: begin
        if (sclk_fall && !early_q) begin
          early_d = 1'b1;
          err_hit = 1'b1;
        end
        if (conv_done) begin
          if (cs_rise) begin
            err_hit = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            sh_load   = 1'b1;
            sh_val    = {1'b0, sample_i};
            sh_len    = CW'(RD_BUSY);
            rd_busy_d = 1'b1;
            st_d      = ST_READ;
          end
        end else if (cs_rise) begin
          err_hit = 1'b1;
          st_d    = ST_CONV;
        end
      end
      ST_READ: begin
        if (cs_rise) begin
          sh_clr      = 1'b1;
          quiet_start = 1'b1;
          st_d        = ST_IDLE;
          if (sh_cnt == rd_exp) begin
            err_hit = 1'b0;
          end else if ((sh_cnt >= CW'(ABORT_MIN)) && (sh_cnt <= CW'(ABORT_MAX))) begin
            rst_pend_d  = 1'b1;
            init_d      = 1'b0;
            busy_mode_d = 1'b0;
            busy_next_d = 1'b0;
          end else begin
            err_hit = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      busy_mode_q <= 1'b0;
      busy_next_q <= 1'b0;
      init_q      <= 1'b0;
      rst_pend_q  <= 1'b0;
      early_q     <= 1'b0;
      rd_busy_q   <= 1'b0;
      result_q    <= '0;
    end else begin
      st_q        <= st_d;
      busy_mode_q <= busy_mode_d;
      busy_next_q <= busy_next_d;
      init_q      <= init_d;
      rst_pend_q  <= rst_pend_d;
      early_q     <= early_d;
      rd_busy_q   <= rd_busy_d;
      result_q    <= result_d;
    end
  end

  assign sdo_o       = (st_q == ST_BWAIT) ? 1'b1 : sh_bit;
  assign sdo_oe_o    = (st_q == ST_BWAIT) | sh_oe;
  assign ready_o     = init_q;
  assign busy_mode_o = busy_mode_q;

  // ---------------- assertions
  p_oe_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lvl && !cs_rise) |-> !sdo_oe_o);
  p_ready_drop_on_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> $past(st_q == ST_READ && cs_rise));
  p_ready_rise_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(conv_done));
  p_mode_switch_points_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(busy_mode_q) |->
      ($past(st_q == ST_IDLE && conv_fall) || $past(st_q == ST_READ && cs_rise)));
endmodule

// File: tb/sar_adc_emu_bench.sv
module sar_adc_emu_bench;
  localparam int W = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_n = 1'b1;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b0;
  logic [W-1:0]  sample = '0;
  logic          sdo, sdo_oe, ready, busy, err;
  logic [15:0]   err_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int exp_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sar_adc_emu u_sar_adc_emu (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_n_i   (conv_n),
    .cs_n_i     (cs_n),
    .sclk_i     (sclk),
    .sample_i   (sample),
    .sdo_o      (sdo),
    .sdo_oe_o   (sdo_oe),
    .ready_o    (ready),
    .busy_mode_o(busy),
    .err_o      (err),
    .err_cnt_o  (err_cnt)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic conv_pulse();
    conv_n = 1'b0; cyc(3); conv_n = 1'b1;
  endtask
  task automatic cs_dn();
    cs_n = 1'b0; cyc(6);
  endtask
  task automatic cs_up();
    cs_n = 1'b1; cyc(12);
  endtask
  task automatic sfall();
    sclk = 1'b1; cyc(4); sclk = 1'b0; cyc(6);
  endtask

  // chip select must already be low; collects bits presented before/after each fall
  task automatic read_bits(input int nf, output logic [W-1:0] w, output logic oe_end);
    w = '0;
    w[W-1] = sdo;
    for (int k = 1; k <= nf; k++) begin
      sfall();
      if (k < W) w[W-1-k] = sdo;
    end
    oe_end = sdo_oe;
  endtask

  task automatic full_conv(input logic [W-1:0] v);
    sample = v;
    conv_pulse();
    cyc(75);
    sample = ~v;  // changed after completion: must not reach the result
  endtask

  task automatic normal_read(input string tag, input logic [W-1:0] v);
    logic [W-1:0] w;
    logic oe_end;
    cs_dn();
    read_bits(W, w, oe_end);
    chk(tag, 32'(w), 32'(v));
    chk({tag, "/R3 oe after last bit"}, 32'(oe_end), 32'd0);
    cs_up();
    chk({tag, "/R3 oe with cs high"}, 32'(sdo_oe), 32'd0);
  endtask

  task automatic soft_reset(input int nf);
    logic [W-1:0] w;
    logic oe_end;
    full_conv(12'h3C3);
    cs_dn();
    read_bits(nf, w, oe_end);
    cs_up();
    chk($sformatf("R4 ready low after %0d-clock abort", nf), 32'(ready), 32'd0);
    chk("R4 busy mode cleared", 32'(busy), 32'd0);
    chk("R4 abort counts no error", 32'(err_cnt), 32'(exp_err));
    conv_pulse();
    cyc(75);
    chk("R5 ready after dummy conversion", 32'(ready), 32'd1);
  endtask

  task automatic arm_busy(input logic [W-1:0] v);
    sample = v;
    conv_pulse();
    cyc(5);
    cs_n = 1'b0; cyc(6); cs_n = 1'b1;
    cyc(10);
    chk("R6 mode not yet active", 32'(busy), 32'd0);
    cyc(60);
    sample = ~v;
    normal_read("R6 read of arming conversion", v);
  endtask

  task automatic busy_cycle(input logic [W-1:0] v);
    logic [W-1:0] w;
    sample = v;
    conv_pulse();
    cyc(5);
    chk("R6 busy mode active from this start", 32'(busy), 32'd1);
    cs_n = 1'b0;
    cyc(10);
    chk("R7 line driven high while converting", 32'({sdo_oe, sdo}), 32'b11);
    cyc(70);
    chk("R7 done flag", 32'({sdo_oe, sdo}), 32'b10);
    sample = ~v;
    w = '0;
    for (int k = 1; k <= W; k++) begin
      sfall();
      w[W-k] = sdo;
    end
    chk("R7 busy read data", 32'(w), 32'(v));
    sfall();
    chk("R3 oe off after 13th fall", 32'(sdo_oe), 32'd0);
    cs_up();
  endtask

  initial begin
    logic [W-1:0] w;
    logic oe_end;
    logic [W-1:0] v;
    int err_lens [7] = '{0, 1, 9, 10, 11, 13, 14};

    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 oe", 32'(sdo_oe), 32'd0);
    chk("R1 ready", 32'(ready), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 err", 32'(err), 32'd0);
    chk("R1 err count", 32'(err_cnt), 32'd0);

    // power-on soft reset, then the whole abort band
    soft_reset(4);
    for (int nf = 2; nf <= 8; nf++) soft_reset(nf);

    // normal-mode data sweep
    for (int i = 0; i < 16; i++) begin
      case (i)
        12: v = 12'h000;
        13: v = 12'hFFF;
        14: v = 12'hA5A;
        15: v = 12'h5A5;
        default: v = W'(1) << i;
      endcase
      full_conv(v);
      normal_read($sformatf("R2 value %03h", v), v);
    end
    chk("R9 spaced starts raise no error", 32'(err_cnt), 32'd0);

    // wrong read lengths
    foreach (err_lens[j]) begin
      full_conv(W'(j * 397 + 5));
      cs_dn();
      read_bits(err_lens[j], w, oe_end);
      cs_up();
      exp_err++;
      chk($sformatf("R10 count after %0d-clock read", err_lens[j]), 32'(err_cnt), 32'(exp_err));
      chk("R10 flag sticky", 32'(err), 32'd1);
      chk("R10 no reset on bad length", 32'(ready), 32'd1);
    end

    // quiet-time violation
    full_conv(12'h7E1);
    cs_dn();
    read_bits(W, w, oe_end);
    cs_n = 1'b1;
    cyc(2);
    sample = 12'h1E7;
    conv_pulse();
    exp_err++;
    cyc(75);
    chk("R9 early start flagged", 32'(err_cnt), 32'(exp_err));
    sample = 12'h000;
    normal_read("R9 conversion still runs", 12'h1E7);

    // busy-indicator mode
    arm_busy(12'h6C9);
    chk("R6 arming adds no error", 32'(err_cnt), 32'(exp_err));
    for (int k = 0; k < 8; k++) busy_cycle(W'((k * 12'h1A3) ^ 12'h0F0));

    // late chip select leaves busy mode
    full_conv(12'h2B4);
    normal_read("R8 late read data", 12'h2B4);
    chk("R8 mode held until next start", 32'(busy), 32'd1);
    sample = 12'hD4B;
    conv_pulse();
    cyc(5);
    chk("R8 mode off at next start", 32'(busy), 32'd0);
    cyc(70);
    sample = 12'h000;
    normal_read("R8 normal read after exit", 12'hD4B);

    // abort inside a busy read clears the mode
    arm_busy(12'h111);
    sample = 12'h999;
    conv_pulse();
    cyc(5);
    chk("R6 re-armed", 32'(busy), 32'd1);
    cs_n = 1'b0;
    cyc(80);
    for (int k = 0; k < 4; k++) sfall();
    cs_up();
    chk("R4 busy abort clears mode", 32'(busy), 32'd0);
    chk("R4 busy abort drops ready", 32'(ready), 32'd0);
    conv_pulse();
    cyc(75);
    chk("R5 ready after busy abort", 32'(ready), 32'd1);
    chk("R10 final error count", 32'(err_cnt), 32'(exp_err));

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule